// File: doc/BRIEF.md
# Paged Memory Address Translator

This block turns the 24-bit addresses issued by a network controller into physical byte addresses in a small board-level RAM. The address space is split into 1 KB pages. A programmable table of 1024 entries says, for each page, which physical frame backs it, whether the two bytes of each 16-bit access must be swapped, and whether the frame lives on the auxiliary expansion bus or in on-board memory. The top four address bits play no part in translation, so the 24-bit space wraps onto a 1 MB window.

The same table serves two translation ports at once: one for the controller and one for the host. Each port gives its result one clock after the request. Software fills the table through a 16-bit word port that has separate write and read-back indices. Pointing the last entry at a low frame lets a fixed structure near the very top of the controller's space sit in ordinary low RAM. A page that selects on-board memory but names a frame beyond the physical RAM is reported as out of range, and no access is issued for it.

Top module: `pmt_page_translator`

## Requirements
- R1: After reset every table entry reads back as zero, and no port reports a valid or out-of-range result.
- R2: Address bits 9:0 appear unchanged as bits 9:0 of the physical address. Bits 23:20 have no effect, so two addresses that differ only there translate identically.
- R3: Address bits 19:10 select the table entry. The physical address is {entry bits 11:0, address bits 9:0}, which is 22 bits wide.
- R4: The swap output is the inverse of entry bit 15. When bit 15 is 1 the page keeps host (big-endian) lane order, and when it is 0 the two bytes are swapped.
- R5: The auxiliary-bus output equals entry bit 13. A value of 0 means on-board memory.
- R6: When the write strobe is high, the 16-bit word is stored at the write index. The read-back output shows the full stored word at the read index one clock after that index is presented, including bits 14 and 12.
- R7: Each request produces exactly one result, either valid or out of range, on the next clock. A cycle without a request produces no result. A table write in the same cycle as a request becomes visible to translation only from the following cycle.
- R8: When entry bit 13 is 0 and the frame number is 256 or more, the result is out of range and not valid. Auxiliary-bus pages accept any 12-bit frame.
- R9: The controller and host ports translate through the same table, independently and in the same cycle.
- R10: Entry 1023 can alias a low frame. For example, with entry 1023 = 0x8000, address 0xFFFFF4 translates to physical 0x0003F4 with no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_we | input | 1 | Table write strobe |
| map_wr_idx | input | 10 | Entry index to write |
| map_wdata | input | 16 | Entry word to write |
| map_rd_idx | input | 10 | Entry index to read back |
| map_rdata | output | 16 | Registered read-back word |
| ctl_req | input | 1 | Controller translation request |
| ctl_addr | input | 24 | Controller address |
| ctl_vld | output | 1 | Controller result valid |
| ctl_oor | output | 1 | Controller result out of range |
| ctl_phys | output | 22 | Controller physical byte address |
| ctl_swap | output | 1 | Controller byte-lane swap |
| ctl_aux | output | 1 | Controller page on auxiliary bus |
| hst_req | input | 1 | Host translation request |
| hst_addr | input | 24 | Host address |
| hst_vld | output | 1 | Host result valid |
| hst_oor | output | 1 | Host result out of range |
| hst_phys | output | 22 | Host physical byte address |
| hst_swap | output | 1 | Host byte-lane swap |
| hst_aux | output | 1 | Host page on auxiliary bus |

## Verification
The assertions check, on every cycle, the properties that follow from the structure of a result. Valid and out-of-range never occur together. A result appears only after a request, and always after one. The offset bits pass through. An out-of-range result always names an on-board page. A table write always lands. Only the bench's scenarios can show the properties that depend on the contents of the table. These are the correct frame and attribute bits, a translation that ignores bits 23:20, the top-entry alias, and the order between a write and a translation in the same cycle. The bench runs a behavioural model of the table against both ports together.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
   // entry layout: these positions are decoded by the page logic
   localparam int PMT_ENTRY_W   = 16;
   localparam int PMT_ORDER_BIT = 15;  // 1 = host lane order, 0 = swapped
   localparam int PMT_AUX_BIT   = 13;  // 1 = auxiliary bus, 0 = on board
   localparam int PMT_FRAME_W   = 12;  // frame number in low bits

   localparam int PMT_PORT_CTL  = 0;
   localparam int PMT_PORT_HST  = 1;
   localparam int PMT_NUM_PORTS = 2;

   function automatic logic [PMT_FRAME_W-1:0] entry_frame(input logic [PMT_ENTRY_W-1:0] e);
      return e[PMT_FRAME_W-1:0];
   endfunction

   function automatic logic entry_swap(input logic [PMT_ENTRY_W-1:0] e);
      return ~e[PMT_ORDER_BIT];
   endfunction

   function automatic logic entry_aux(input logic [PMT_ENTRY_W-1:0] e);
      return e[PMT_AUX_BIT];
   endfunction
endpackage

// File: rtl/pmt_map_table.sv
module pmt_map_table #(
   parameter int IDX_W   = 10,
   parameter int ENTRY_W = 16,
   parameter int NUM_LK  = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [ENTRY_W-1:0]               wr_data,
   input  logic [IDX_W-1:0]                 rd_idx,
   output logic [ENTRY_W-1:0]               rd_data,
   input  logic [NUM_LK-1:0][IDX_W-1:0]     lk_idx,
   output logic [NUM_LK-1:0][ENTRY_W-1:0]   lk_entry
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENTRY_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en) mem_q[wr_idx] <= wr_data;
         rd_data <= mem_q[rd_idx];
      end
   end

   // one combinational read port per translation port
   for (genvar g = 0; g < NUM_LK; g++) begin : g_lookup
      assign lk_entry[g] = mem_q[lk_idx[g]];
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_data))); // R6
endmodule

// File: rtl/pmt_entry_decode.sv
module pmt_entry_decode
   import pmt_pkg::*;
#(
   parameter int PHYS_PAGES = 256
) (
   input  logic [PMT_ENTRY_W-1:0] entry,
   output logic [PMT_FRAME_W-1:0] frame,
   output logic                   swap,
   output logic                   aux,
   output logic                   oor
);
   localparam int PAGE_BITS = (PHYS_PAGES > 1) ? $clog2(PHYS_PAGES) : 1;
   localparam bit IS_POW2   = (PHYS_PAGES == (1 << PAGE_BITS));

   logic beyond;

   assign frame = entry_frame(entry);
   assign swap  = entry_swap(entry);
   assign aux   = entry_aux(entry);

   // range check variant picked by the page count
   if (PHYS_PAGES >= (1 << PMT_FRAME_W)) begin : g_full
      assign beyond = 1'b0;
   end else if (IS_POW2) begin : g_pow2
      assign beyond = |frame[PMT_FRAME_W-1:PAGE_BITS];
   end else begin : g_cmp
      assign beyond = (32'(frame) >= PHYS_PAGES);
   end

   // auxiliary-bus pages are not bounded by on-board RAM
   assign oor = beyond & ~aux;
endmodule

// File: rtl/pmt_xlate_stage.sv
module pmt_xlate_stage
   import pmt_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int IDX_W  = 10,
   parameter int OFFS_W = 10,
   localparam int PA_W  = PMT_FRAME_W + OFFS_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req,
   input  logic [ADDR_W-1:0]      addr,
   output logic [IDX_W-1:0]       idx,
   input  logic [PMT_FRAME_W-1:0] frame,
   input  logic                   swap_in,
   input  logic                   aux_in,
   input  logic                   oor_in,
   output logic                   vld_q,
   output logic                   oor_q,
   output logic [PA_W-1:0]        phys_q,
   output logic                   swap_q,
   output logic                   aux_q
);
   localparam int USED_W = IDX_W + OFFS_W;

   assign idx = addr[USED_W-1:OFFS_W];

   if (ADDR_W > USED_W) begin : g_hi_ignored
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:USED_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         oor_q  <= 1'b0;
         phys_q <= '0;
         swap_q <= 1'b0;
         aux_q  <= 1'b0;
      end else begin
         vld_q <= req & ~oor_in;
         oor_q <= req & oor_in;
         if (req) begin
            phys_q <= {frame, addr[OFFS_W-1:0]};
            swap_q <= swap_in;
            aux_q  <= aux_in;
         end
      end
   end

   AST_VLD_OOR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_q && oor_q)); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req) |-> (!vld_q && !oor_q)); // R7
   AST_ALWAYS_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req && rst_n) |-> (vld_q || oor_q)); // R7
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> (phys_q[OFFS_W-1:0] == $past(addr[OFFS_W-1:0]))); // R2
   AST_OOR_ONBOARD: assert property (@(posedge clk) disable iff (!rst_n)
      oor_q |-> !aux_q); // R8
endmodule

// File: rtl/pmt_page_translator.sv
module pmt_page_translator
   import pmt_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int IDX_W      = 10,
   parameter int OFFS_W     = 10,
   parameter int PHYS_PAGES = 256,
   localparam int PA_W      = PMT_FRAME_W + OFFS_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   map_we,
   input  logic [IDX_W-1:0]       map_wr_idx,
   input  logic [PMT_ENTRY_W-1:0] map_wdata,
   input  logic [IDX_W-1:0]       map_rd_idx,
   output logic [PMT_ENTRY_W-1:0] map_rdata,
   input  logic                   ctl_req,
   input  logic [ADDR_W-1:0]      ctl_addr,
   output logic                   ctl_vld,
   output logic                   ctl_oor,
   output logic [PA_W-1:0]        ctl_phys,
   output logic                   ctl_swap,
   output logic                   ctl_aux,
   input  logic                   hst_req,
   input  logic [ADDR_W-1:0]      hst_addr,
   output logic                   hst_vld,
   output logic                   hst_oor,
   output logic [PA_W-1:0]        hst_phys,
   output logic                   hst_swap,
   output logic                   hst_aux
);
   localparam int NP = PMT_NUM_PORTS;

   initial begin
      AST_CFG_ADDR_SPLIT: assert (ADDR_W >= IDX_W + OFFS_W)
         else $error("address too narrow for index plus offset"); // R3
      AST_CFG_PAGES: assert (PHYS_PAGES >= 1)
         else $error("physical page count must be positive"); // R8
      AST_CFG_ENTRY: assert (PMT_ENTRY_W > PMT_ORDER_BIT && PMT_ORDER_BIT > PMT_AUX_BIT
                             && PMT_AUX_BIT >= PMT_FRAME_W)
         else $error("entry fields overlap"); // R4
   end

   logic [NP-1:0]                  req_v;
   logic [NP-1:0][ADDR_W-1:0]      addr_v;
   logic [NP-1:0][IDX_W-1:0]       idx_v;
   logic [NP-1:0][PMT_ENTRY_W-1:0] ent_v;
   logic [NP-1:0]                  vld_v, oor_v, swap_v, aux_v;
   logic [NP-1:0][PA_W-1:0]        phys_v;

   assign req_v[PMT_PORT_CTL]  = ctl_req;
   assign addr_v[PMT_PORT_CTL] = ctl_addr;
   assign req_v[PMT_PORT_HST]  = hst_req;
   assign addr_v[PMT_PORT_HST] = hst_addr;

   pmt_map_table #(
      .IDX_W   (IDX_W),
      .ENTRY_W (PMT_ENTRY_W),
      .NUM_LK  (NP)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (map_we),
      .wr_idx   (map_wr_idx),
      .wr_data  (map_wdata),
      .rd_idx   (map_rd_idx),
      .rd_data  (map_rdata),
      .lk_idx   (idx_v),
      .lk_entry (ent_v)
   );

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic [PMT_FRAME_W-1:0] frame;
      logic                   swap, aux, oor;

      pmt_entry_decode #(.PHYS_PAGES(PHYS_PAGES)) u_dec (
         .entry (ent_v[p]),
         .frame (frame),
         .swap  (swap),
         .aux   (aux),
         .oor   (oor)
      );

      pmt_xlate_stage #(
         .ADDR_W (ADDR_W),
         .IDX_W  (IDX_W),
         .OFFS_W (OFFS_W)
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .req     (req_v[p]),
         .addr    (addr_v[p]),
         .idx     (idx_v[p]),
         .frame   (frame),
         .swap_in (swap),
         .aux_in  (aux),
         .oor_in  (oor),
         .vld_q   (vld_v[p]),
         .oor_q   (oor_v[p]),
         .phys_q  (phys_v[p]),
         .swap_q  (swap_v[p]),
         .aux_q   (aux_v[p])
      );
   end

   assign ctl_vld  = vld_v[PMT_PORT_CTL];
   assign ctl_oor  = oor_v[PMT_PORT_CTL];
   assign ctl_phys = phys_v[PMT_PORT_CTL];
   assign ctl_swap = swap_v[PMT_PORT_CTL];
   assign ctl_aux  = aux_v[PMT_PORT_CTL];
   assign hst_vld  = vld_v[PMT_PORT_HST];
   assign hst_oor  = oor_v[PMT_PORT_HST];
   assign hst_phys = phys_v[PMT_PORT_HST];
   assign hst_swap = swap_v[PMT_PORT_HST];
   assign hst_aux  = aux_v[PMT_PORT_HST];

   AST_TWO_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_vld && hst_vld && $past(ctl_addr[IDX_W+OFFS_W-1:0] == hst_addr[IDX_W+OFFS_W-1:0]))
      |-> (ctl_phys == hst_phys && ctl_swap == hst_swap && ctl_aux == hst_aux)); // R9
endmodule

// File: tb/pmt_page_translator_test.sv
module pmt_page_translator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_we = 1'b0;
   logic [9:0]  map_wr_idx = '0;
   logic [15:0] map_wdata = '0;
   logic [9:0]  map_rd_idx = '0;
   logic [15:0] map_rdata;
   logic        ctl_req = 1'b0;
   logic [23:0] ctl_addr = '0;
   logic        ctl_vld, ctl_oor, ctl_swap, ctl_aux;
   logic [21:0] ctl_phys;
   logic        hst_req = 1'b0;
   logic [23:0] hst_addr = '0;
   logic        hst_vld, hst_oor, hst_swap, hst_aux;
   logic [21:0] hst_phys;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pmt_page_translator uut (
      .clk(clk), .rst_n(rst_n),
      .map_we(map_we), .map_wr_idx(map_wr_idx), .map_wdata(map_wdata),
      .map_rd_idx(map_rd_idx), .map_rdata(map_rdata),
      .ctl_req(ctl_req), .ctl_addr(ctl_addr), .ctl_vld(ctl_vld), .ctl_oor(ctl_oor),
      .ctl_phys(ctl_phys), .ctl_swap(ctl_swap), .ctl_aux(ctl_aux),
      .hst_req(hst_req), .hst_addr(hst_addr), .hst_vld(hst_vld), .hst_oor(hst_oor),
      .hst_phys(hst_phys), .hst_swap(hst_swap), .hst_aux(hst_aux)
   );

   // behavioural reference: table as an array, results from the rules
   logic [15:0] ref_map [0:1023];
   logic [25:0] exp_ctl, exp_hst;
   logic [15:0] exp_rdata;

   function automatic logic [25:0] ref_xlate(input logic rq, input logic [23:0] a,
                                             input logic [15:0] e);
      int  frame_n = int'(e[11:0]);
      logic aux_b  = e[13];
      logic bad    = !aux_b && frame_n >= 256;
      return {rq && !bad, rq && bad, !e[15], aux_b, e[11:0], a[9:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) ref_map[i] = 16'h0000;
         exp_ctl = '0; exp_hst = '0; exp_rdata = '0;
      end else begin
         exp_ctl   = ref_xlate(ctl_req, ctl_addr, ref_map[ctl_addr[19:10]]);
         exp_hst   = ref_xlate(hst_req, hst_addr, ref_map[hst_addr[19:10]]);
         exp_rdata = ref_map[map_rd_idx];
         if (map_we) ref_map[map_wr_idx] = map_wdata;
      end
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // compare both ports and read-back on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(ctl_vld == exp_ctl[25], "R7 ctl valid", 32'(ctl_vld), 32'(exp_ctl[25]));
         chk(ctl_oor == exp_ctl[24], "R8 ctl out-of-range", 32'(ctl_oor), 32'(exp_ctl[24]));
         if (exp_ctl[25]) begin
            chk(ctl_phys == exp_ctl[21:0], "R3 ctl phys", 32'(ctl_phys), 32'(exp_ctl[21:0]));
            chk(ctl_swap == exp_ctl[23], "R4 ctl swap", 32'(ctl_swap), 32'(exp_ctl[23]));
            chk(ctl_aux == exp_ctl[22], "R5 ctl aux", 32'(ctl_aux), 32'(exp_ctl[22]));
         end
         chk(hst_vld == exp_hst[25], "R9 hst valid", 32'(hst_vld), 32'(exp_hst[25]));
         chk(hst_oor == exp_hst[24], "R9 hst out-of-range", 32'(hst_oor), 32'(exp_hst[24]));
         if (exp_hst[25]) begin
            chk(hst_phys == exp_hst[21:0], "R9 hst phys", 32'(hst_phys), 32'(exp_hst[21:0]));
            chk(hst_swap == exp_hst[23], "R9 hst swap", 32'(hst_swap), 32'(exp_hst[23]));
            chk(hst_aux == exp_hst[22], "R9 hst aux", 32'(hst_aux), 32'(exp_hst[22]));
         end
         chk(map_rdata == exp_rdata, "R6 read-back", 32'(map_rdata), 32'(exp_rdata));
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] i, input logic [15:0] d);
      map_we = 1'b1; map_wr_idx = i; map_wdata = d;
      cyc();
      map_we = 1'b0;
   endtask

   initial begin
      repeat (3) cyc();
      // R1: outputs quiet in reset
      chk(!ctl_vld && !ctl_oor && !hst_vld && !hst_oor, "R1 reset outputs",
          {ctl_vld, ctl_oor, hst_vld, hst_oor}, 32'h0);
      rst_n = 1'b1;
      map_rd_idx = 10'd1023;
      cyc();
      chk(map_rdata == 16'h0, "R1 entry 1023 cleared", 32'(map_rdata), 32'h0);
      map_rd_idx = 10'd513;
      cyc();
      chk(map_rdata == 16'h0, "R1 entry 513 cleared", 32'(map_rdata), 32'h0);

      // R6: all bits stored, including unused ones
      wr(10'd77, 16'h5A5A);
      map_rd_idx = 10'd77;
      cyc();
      chk(map_rdata == 16'h5A5A, "R6 full word read-back", 32'(map_rdata), 32'h5A5A);

      // R10: top entry aliases frame 0
      wr(10'd1023, 16'h8000);
      ctl_req = 1'b1; ctl_addr = 24'hFFFFF4;
      cyc();
      ctl_req = 1'b0;
      chk(ctl_vld && ctl_phys == 22'h0003F4, "R10 alias phys", 32'(ctl_phys), 32'h3F4);
      chk(ctl_swap == 1'b0, "R10 alias no swap", 32'(ctl_swap), 32'h0);

      // R2 and R9: top nibble ignored, both ports in one cycle
      wr(10'h048, 16'h0077);
      ctl_req = 1'b1; ctl_addr = 24'h012345;
      hst_req = 1'b1; hst_addr = 24'hF12345;
      cyc();
      ctl_req = 1'b0; hst_req = 1'b0;
      chk(ctl_vld && ctl_phys == 22'h01DF45, "R2 ctl phys", 32'(ctl_phys), 32'h1DF45);
      chk(hst_vld && hst_phys == 22'h01DF45, "R2 hst phys top nibble ignored",
          32'(hst_phys), 32'h1DF45);
      chk(ctl_swap == 1'b1 && ctl_aux == 1'b0, "R4 little-endian page swaps",
          {ctl_swap, ctl_aux}, 32'h2);

      // R8: on-board frame 256 rejected, aux frame 0xFFF accepted
      wr(10'd5, 16'h0100);
      wr(10'd6, 16'h2FFF);
      ctl_req = 1'b1; ctl_addr = 24'h001400;
      hst_req = 1'b1; hst_addr = 24'h0019FF;
      cyc();
      ctl_req = 1'b0; hst_req = 1'b0;
      chk(ctl_oor && !ctl_vld, "R8 on-board frame 256 out of range",
          {ctl_vld, ctl_oor}, 32'h1);
      chk(hst_vld && hst_phys == 22'h3FFDFF && hst_aux, "R5 aux frame accepted",
          32'(hst_phys), 32'h3FFDFF);

      // R7: write and request in one cycle, translation sees old entry
      map_we = 1'b1; map_wr_idx = 10'h048; map_wdata = 16'h8003;
      ctl_req = 1'b1; ctl_addr = 24'h012345;
      cyc();
      map_we = 1'b0;
      chk(ctl_phys == 22'h01DF45, "R7 same-cycle write not seen", 32'(ctl_phys), 32'h1DF45);
      cyc();
      ctl_req = 1'b0;
      chk(ctl_phys == 22'h000F45 && !ctl_swap, "R7 write seen next cycle",
          32'(ctl_phys), 32'hF45);
      cyc();
      chk(!ctl_vld && !ctl_oor, "R7 no result without request", {ctl_vld, ctl_oor}, 32'h0);

      // mixed traffic against the model
      for (int n = 0; n < 4000; n++) begin
         logic [15:0] d;
         d = 16'($urandom);
         if ($urandom_range(0, 1) == 1) d[11:8] = 4'h0;
         map_we     = ($urandom_range(0, 2) == 0);
         map_wr_idx = 10'({$urandom_range(0, 15), 6'($urandom_range(0, 3))});
         map_wdata  = d;
         map_rd_idx = 10'({$urandom_range(0, 15), 6'($urandom_range(0, 3))});
         ctl_req    = ($urandom_range(0, 3) != 0);
         ctl_addr   = {4'($urandom), 4'($urandom_range(0, 15)), 6'($urandom_range(0, 3)),
                       10'($urandom)};
         hst_req    = ($urandom_range(0, 1) == 1);
         hst_addr   = {4'($urandom), 4'($urandom_range(0, 15)), 6'($urandom_range(0, 3)),
                       10'($urandom)};
         cyc();
      end
      map_we = 1'b0; ctl_req = 1'b0; hst_req = 1'b0;
      cyc();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule